// File: doc/BRIEF.md
# Shifted-Broadcast 1D Stencil Operand Feeder

This block holds a short horizontal run of pixels in a shift register and a row of filter coefficients, and turns them into the two operand vectors that a wide array of two-input ALUs needs. A single request covers several overlapping 1D stencil positions at once. Each position is a shifted copy of the pixel window, and the coefficient row is repeated for every position. No shuffle instructions and no repeated reloads of the same pixels are needed.

Pixels arrive sixteen at a time. The existing contents can either move toward element 0 or stay where they are. A convolve request chooses a kernel width (4, 8 or 16 taps), a starting element and an optional symmetric mode. In symmetric mode, mirrored pixel pairs are summed ahead of the multipliers, so only half of the taps in each position carry work. Requests that would read past the end of the register are rejected with an error pulse.

Top module: `stencil_feeder`

## Requirements
- R1: After reset `outValid` and `outErr` are 0, both output vectors are all zero, and every pixel element and coefficient entry reads as 0.
- R2: A pixel load with `pixShift`=1 moves element i+16 into element i for i in 0..23, and writes new pixel n (`pixData[n*10 +: 10]`) into element 24+n.
- R3: A pixel load with `pixShift`=0 writes new pixel n into element 24+n and leaves elements 0..23 unchanged.
- R4: A coefficient load writes entry j from `coefData[j*10 +: 10]`.
- R5: `convSize` codes 0, 1 and 2 select T = 4, 8 and 16 taps, giving P = 64/T positions. Lane L = k*T + j (k = L/T, j = L mod T) carries pixel element `convOffset`+k+j in `pixVec[L*11 +: 11]` (zero-extended) and coefficient j in `coefVec[L*10 +: 10]`.
- R6: A request accepted on clock edge n produces a one-cycle `outValid` pulse that is visible after edge n+1.
- R7: When `convSize`=3 or `convOffset`+P+T−1 > 40, the request produces a one-cycle `outErr` pulse at the time `outValid` would have been visible, and `outValid` stays 0. The two flags are never high together.
- R8: With `convSym`=1, a lane with j < T/2 carries element s+j plus element s+T−1−j (where s = `convOffset`+k) as an 11-bit sum, together with coefficient j. A lane with j ≥ T/2 carries 0 in both vectors.
- R9: When a pixel load and a request arrive on the same edge, the load is applied first, and the output built from that request uses the updated contents.
- R10: On cycles without `outValid`, both output vectors keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixLoad | input | 1 | Load sixteen pixels this cycle |
| pixShift | input | 1 | Move existing pixels down by sixteen during the load |
| pixData | input | 160 | Sixteen 10-bit pixels, pixel n at bits n*10 |
| coefLoad | input | 1 | Load the coefficient row |
| coefData | input | 160 | Sixteen 10-bit coefficients |
| convReq | input | 1 | Convolve request strobe |
| convSize | input | 2 | Kernel width code: 0=4, 1=8, 2=16, 3=invalid |
| convOffset | input | 6 | First pixel element of position 0 |
| convSym | input | 1 | Symmetric pre-addition mode |
| outValid | output | 1 | Operand vectors are fresh this cycle |
| outErr | output | 1 | The request was rejected for range or size |
| pixVec | output | 704 | 64 lanes of 11-bit pixel operands |
| coefVec | output | 640 | 64 lanes of 10-bit coefficient operands |

## Verification
The bench uses the default build: 40 elements of 10 bits, 16-pixel loads, 16 coefficients and 64 lanes. With these sizes each kernel width has its own last legal offset (21, 25 and 21). The bench probes those offsets and the first illegal offset after each one, so every position count reaches the end of the register. Pixel values go up to 1023, so symmetric sums exercise the carry into the eleventh bit.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int OFF_W = 6;

  typedef enum logic [1:0] {
    SZ_TAP4  = 2'd0,
    SZ_TAP8  = 2'd1,
    SZ_TAP16 = 2'd2,
    SZ_BAD   = 2'd3
  } size_e;

  typedef struct packed {
    logic             loadEn;
    logic             shiftEn;
    logic             coefEn;
    logic             emit;
    logic             fault;
    logic             sym;
    size_e            sizeSel;
    logic [OFF_W-1:0] offset;
  } strobe_t;

  function automatic int tapsOf(size_e s);
    case (s)
      SZ_TAP4:  return 4;
      SZ_TAP8:  return 8;
      default:  return 16;
    endcase
  endfunction
endpackage

// File: rtl/stencil_ctrl.sv
module stencil_ctrl
  import stencil_pkg::*;
#(
  parameter int DEPTH = 40,
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixLoad,
  input  logic             pixShift,
  input  logic             coefLoad,
  input  logic             convReq,
  input  logic [1:0]       convSize,
  input  logic [OFF_W-1:0] convOffset,
  input  logic             convSym,
  output strobe_t          strb
);
  logic             reqQ;
  size_e            sizeQ;
  logic [OFF_W-1:0] offQ;
  logic             symQ;
  logic             inRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ  <= 1'b0;
      sizeQ <= SZ_TAP4;
      offQ  <= '0;
      symQ  <= 1'b0;
    end else begin
      reqQ <= convReq;
      if (convReq) begin
        sizeQ <= size_e'(convSize);
        offQ  <= convOffset;
        symQ  <= convSym;
      end
    end
  end

  always_comb begin
    int tapsI;
    int posI;
    int lastI;
    tapsI   = tapsOf(sizeQ);
    posI    = LANES / tapsI;
    lastI   = int'(offQ) + posI + tapsI - 1;
    inRange = (sizeQ != SZ_BAD) && (lastI <= DEPTH);
  end

  always_comb begin
    strb.loadEn  = pixLoad;
    strb.shiftEn = pixShift;
    strb.coefEn  = coefLoad;
    strb.emit    = reqQ && inRange;
    strb.fault   = reqQ && !inRange;
    strb.sym     = symQ;
    strb.sizeSel = sizeQ;
    strb.offset  = offQ;
  end

  // R6
  emit_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |-> $past(convReq));

  // R7
  bad_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convSize == 2'd3) |=> (strb.fault && !strb.emit));
endmodule

// File: rtl/stencil_dpath.sv
module stencil_dpath
  import stencil_pkg::*;
#(
  parameter int ELEM_W = 10,
  parameter int DEPTH  = 40,
  parameter int LOAD_N = 16,
  parameter int NCOEF  = 16,
  parameter int LANES  = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [LOAD_N*ELEM_W-1:0]    pixIn,
  input  logic [NCOEF*ELEM_W-1:0]     coefIn,
  output logic                        validQ,
  output logic                        errQ,
  output logic [LANES*(ELEM_W+1)-1:0] pixVecQ,
  output logic [LANES*ELEM_W-1:0]     coefVecQ
);
  localparam int PW    = ELEM_W + 1;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(NCOEF);
  localparam int KEEPN = DEPTH - LOAD_N;

  logic [ELEM_W-1:0] sr       [DEPTH];
  logic [ELEM_W-1:0] coefRow  [NCOEF];
  logic [PW-1:0]     lanePix  [LANES];
  logic [ELEM_W-1:0] laneCoef [LANES];

  // pixel shift register: lower part moves or holds, upper part takes new data
  for (genvar g = 0; g < DEPTH; g++) begin : g_elem
    if (g < KEEPN) begin : g_keep
      always_ff @(posedge clk) begin
        if (!rstN)                            sr[g] <= '0;
        else if (strb.loadEn && strb.shiftEn) sr[g] <= sr[g+LOAD_N];
      end
    end else begin : g_fill
      always_ff @(posedge clk) begin
        if (!rstN)            sr[g] <= '0;
        else if (strb.loadEn) sr[g] <= pixIn[(g-KEEPN)*ELEM_W +: ELEM_W];
      end
    end
  end

  for (genvar c = 0; c < NCOEF; c++) begin : g_coef
    always_ff @(posedge clk) begin
      if (!rstN)            coefRow[c] <= '0;
      else if (strb.coefEn) coefRow[c] <= coefIn[c*ELEM_W +: ELEM_W];
    end
  end

  // broadcast network: each lane picks its window element and tap
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    always_comb begin
      int t;
      int k;
      int j;
      int a;
      int b;
      logic [PW-1:0] pa;
      logic [PW-1:0] pb;
      t  = tapsOf(strb.sizeSel);
      k  = L / t;
      j  = L % t;
      a  = int'(strb.offset) + k + j;
      b  = int'(strb.offset) + k + t - 1 - j;
      pa = (a < DEPTH) ? {1'b0, sr[a[AW-1:0]]} : '0;
      pb = (b < DEPTH) ? {1'b0, sr[b[AW-1:0]]} : '0;
      if (strb.sym) begin
        if (j < t / 2) begin
          lanePix[L]  = pa + pb;
          laneCoef[L] = coefRow[j[CW-1:0]];
        end else begin
          lanePix[L]  = '0;
          laneCoef[L] = '0;
        end
      end else begin
        lanePix[L]  = pa;
        laneCoef[L] = coefRow[j[CW-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      errQ     <= 1'b0;
      pixVecQ  <= '0;
      coefVecQ <= '0;
    end else begin
      validQ <= strb.emit;
      errQ   <= strb.fault;
      if (strb.emit) begin
        for (int L = 0; L < LANES; L++) begin
          pixVecQ[L*PW +: PW]          <= lanePix[L];
          coefVecQ[L*ELEM_W +: ELEM_W] <= laneCoef[L];
        end
      end
    end
  end

  // R7
  no_valid_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(validQ && errQ));

  // R10
  hold_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validQ |-> ($stable(pixVecQ) && $stable(coefVecQ)));

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && strb.shiftEn) |=> (sr[0] == $past(sr[LOAD_N])));

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && !strb.shiftEn) |=> $stable(sr[0]));
endmodule

// File: rtl/stencil_feeder.sv
module stencil_feeder
  import stencil_pkg::*;
#(
  parameter int ELEM_W = 10,
  parameter int DEPTH  = 40,
  parameter int LOAD_N = 16,
  parameter int NCOEF  = 16,
  parameter int LANES  = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pixLoad,
  input  logic                        pixShift,
  input  logic [LOAD_N*ELEM_W-1:0]    pixData,
  input  logic                        coefLoad,
  input  logic [NCOEF*ELEM_W-1:0]     coefData,
  input  logic                        convReq,
  input  logic [1:0]                  convSize,
  input  logic [OFF_W-1:0]            convOffset,
  input  logic                        convSym,
  output logic                        outValid,
  output logic                        outErr,
  output logic [LANES*(ELEM_W+1)-1:0] pixVec,
  output logic [LANES*ELEM_W-1:0]     coefVec
);
  strobe_t strb;

  stencil_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .pixLoad(pixLoad), .pixShift(pixShift),
    .coefLoad(coefLoad), .convReq(convReq), .convSize(convSize),
    .convOffset(convOffset), .convSym(convSym), .strb(strb)
  );

  stencil_dpath #(
    .ELEM_W(ELEM_W), .DEPTH(DEPTH), .LOAD_N(LOAD_N),
    .NCOEF(NCOEF), .LANES(LANES)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .pixIn(pixData), .coefIn(coefData),
    .validQ(outValid), .errQ(outErr), .pixVecQ(pixVec), .coefVecQ(coefVec)
  );
endmodule

// File: tb/stencil_feeder_tb.sv
module stencil_feeder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;
  localparam int D = 40;
  localparam int NL = 16;
  localparam int NC = 16;
  localparam int LN = 64;
  localparam int PW = W + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixLoad = 1'b0, pixShift = 1'b0, coefLoad = 1'b0;
  logic convReq = 1'b0, convSym = 1'b0;
  logic [1:0] convSize = 2'd0;
  logic [5:0] convOffset = 6'd0;
  logic [NL*W-1:0] pixData = '0;
  logic [NC*W-1:0] coefData = '0;
  logic outValid, outErr;
  logic [LN*PW-1:0] pixVec;
  logic [LN*W-1:0] coefVec;

  int checks = 0;
  int errors = 0;
  int loadCount = 0;

  // reference model state
  int mSr[D];
  int mCoef[NC];
  int mPix[LN];
  int mCf[LN];
  bit mValid = 0, mErr = 0;
  bit pReq = 0, pSym = 0;
  int pSize = 0, pOff = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stencil_feeder dut_i (
    .clk(clk), .rstN(rstN), .pixLoad(pixLoad), .pixShift(pixShift),
    .pixData(pixData), .coefLoad(coefLoad), .coefData(coefData),
    .convReq(convReq), .convSize(convSize), .convOffset(convOffset),
    .convSym(convSym), .outValid(outValid), .outErr(outErr),
    .pixVec(pixVec), .coefVec(coefVec)
  );

  initial begin
    for (int i = 0; i < D; i++) mSr[i] = 0;
    for (int i = 0; i < NC; i++) mCoef[i] = 0;
    for (int i = 0; i < LN; i++) begin mPix[i] = 0; mCf[i] = 0; end
  end

  task automatic compare(string tag);
    int badLane;
    checks++;
    if (outValid !== mValid) begin
      errors++;
      $display("FAIL %s outValid actual %0b expected %0b", tag, outValid, mValid);
    end
    checks++;
    if (outErr !== mErr) begin
      errors++;
      $display("FAIL %s outErr actual %0b expected %0b", tag, outErr, mErr);
    end
    badLane = -1;
    for (int L = 0; L < LN; L++)
      if (badLane < 0 && (int'(pixVec[L*PW +: PW]) != mPix[L] || $isunknown(pixVec[L*PW +: PW])))
        badLane = L;
    checks++;
    if (badLane >= 0) begin
      errors++;
      $display("FAIL %s pixVec lane %0d actual %0d expected %0d", tag, badLane,
               pixVec[badLane*PW +: PW], mPix[badLane]);
    end
    badLane = -1;
    for (int L = 0; L < LN; L++)
      if (badLane < 0 && (int'(coefVec[L*W +: W]) != mCf[L] || $isunknown(coefVec[L*W +: W])))
        badLane = L;
    checks++;
    if (badLane >= 0) begin
      errors++;
      $display("FAIL %s coefVec lane %0d actual %0d expected %0d", tag, badLane,
               coefVec[badLane*W +: W], mCf[badLane]);
    end
  endtask

  // one clock: update model at the edge, compare at the falling edge
  task automatic tick(string tag);
    @(posedge clk);
    mValid = 0;
    mErr = 0;
    if (pReq) begin
      int t, p;
      t = (pSize == 0) ? 4 : (pSize == 1) ? 8 : 16;
      p = LN / t;
      if (pSize == 3 || pOff + p + t - 1 > D) mErr = 1;
      else begin
        mValid = 1;
        for (int L = 0; L < LN; L++) begin
          int k, j, s;
          k = L / t; j = L % t; s = pOff + k;
          if (pSym) begin
            if (j < t / 2) begin
              mPix[L] = mSr[s + j] + mSr[s + t - 1 - j];
              mCf[L] = mCoef[j];
            end else begin
              mPix[L] = 0; mCf[L] = 0;
            end
          end else begin
            mPix[L] = mSr[s + j];
            mCf[L] = mCoef[j];
          end
        end
      end
    end
    if (pixLoad) begin
      if (pixShift) for (int i = 0; i < D - NL; i++) mSr[i] = mSr[i + NL];
      for (int i = 0; i < NL; i++) mSr[D - NL + i] = int'(pixData[i*W +: W]);
    end
    if (coefLoad) for (int i = 0; i < NC; i++) mCoef[i] = int'(coefData[i*W +: W]);
    pReq = convReq;
    if (convReq) begin
      pSize = int'(convSize); pOff = int'(convOffset); pSym = convSym;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic setPixels(bit shift);
    loadCount++;
    pixLoad = 1; pixShift = shift;
    for (int i = 0; i < NL; i++)
      pixData[i*W +: W] = W'((loadCount * 211 + i * 67 + 900) % 1024);
  endtask

  task automatic doLoad(bit shift, string tag);
    setPixels(shift);
    tick(tag);
    pixLoad = 0; pixShift = 0;
  endtask

  task automatic setConv(int size, int off, bit sym);
    convReq = 1; convSize = 2'(size); convOffset = 6'(off); convSym = sym;
  endtask

  task automatic doConv(int size, int off, bit sym, string tag);
    setConv(size, off, sym);
    tick(tag);
    convReq = 0;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    compare("R1 reset state");
    tick("R1 idle after reset");
    // request on empty register reads zeros everywhere (R1)
    doConv(2, 0, 0, "R1 zero contents");

    coefLoad = 1;
    for (int i = 0; i < NC; i++) coefData[i*W +: W] = W'(1000 - i * 61);
    tick("R4 coefficient load");
    coefLoad = 0;

    doLoad(1, "R2 shift load a");
    doLoad(1, "R2 shift load b");
    doLoad(1, "R2 shift load c");
    doConv(2, 0, 0, "R5 R4 R2 taps16 off0");
    doConv(2, 8, 0, "R5 taps16 off8");
    doConv(2, 21, 0, "R5 taps16 last legal offset");
    doConv(2, 22, 0, "R7 taps16 out of range");
    doConv(1, 25, 0, "R5 taps8 last legal offset");
    doConv(1, 26, 0, "R7 taps8 out of range");
    doConv(0, 3, 0, "R5 taps4 off3");
    doConv(0, 21, 0, "R5 taps4 last legal offset");
    doConv(0, 22, 0, "R7 taps4 out of range");
    doConv(3, 0, 0, "R7 invalid size code");
    doConv(2, 5, 1, "R8 symmetric taps16");
    doConv(1, 25, 1, "R8 symmetric taps8");
    doConv(0, 0, 1, "R8 symmetric taps4");

    doLoad(0, "R3 load without shift");
    doConv(2, 0, 0, "R3 low elements kept");
    doConv(1, 20, 0, "R3 upper elements replaced");

    // same-edge load and request
    setPixels(1);
    setConv(2, 21, 0);
    tick("R9 load and request together");
    pixLoad = 0; pixShift = 0; convReq = 0;
    tick("R9 output uses loaded data");

    // back-to-back requests then idle
    setConv(0, 1, 0);
    tick("R6 back to back first");
    setConv(1, 2, 1);
    tick("R6 back to back second");
    convReq = 0;
    tick("R6 second output");
    for (int i = 0; i < 4; i++) tick("R10 vectors held while idle");
    doLoad(1, "R10 load alone does not touch outputs");
    tick("R10 still held");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule